// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence Filter

This block watches the stream of results coming out of a sensor converter and raises an active-low interrupt when readings leave a programmed window. Each time a conversion finishes, the converter pulses a done strobe alongside a 16-bit result. The block compares that result against a lower and an upper limit. A per-block counter tracks how many consecutive results fell outside the window. A 4-bit persistence code selects the firing rule. Code zero fires on every conversion. Code one fires on any single excursion. Codes two and above need that many back-to-back excursions.

A 2-bit mode input gates the whole function. When the interrupt is armed, a fired interrupt latches and holds the pin low until the register side pulses a clear. The clear also restarts the excursion count. The limits and the codes come from register storage outside the block, and the bus and the converter also sit outside it.

Top module: `thr_irq_filter`

## Requirements
- R1: A result is outside the window only when it is strictly less than the lower limit or strictly greater than the upper limit. A result equal to either limit counts as inside.
- R2: With persistence code 0, every accepted conversion fires the interrupt, whether the result is inside or outside the window.
- R3: With persistence code 1, a single accepted conversion outside the window fires the interrupt.
- R4: With persistence code N, for N from 2 to 15, the interrupt fires on the Nth consecutive accepted out-of-window conversion and not before.
- R5: An accepted conversion inside the window resets the excursion count to zero, so only unbroken runs of excursions count.
- R6: Once fired in armed mode, the interrupt stays asserted through any later conversions until a clear pulse arrives. The clear deasserts it and restarts the excursion count from zero.
- R7: When a clear and a conversion strobe occur in the same cycle, the clear wins and that conversion is discarded. It neither fires nor counts.
- R8: Mode code 2'b00 disables the block. The pin reads high at once, any pending interrupt is dropped, and the count is held at zero, so a later re-arm needs a full fresh run.
- R9: Only mode code 2'b01 arms the interrupt. Codes 2'b10 and 2'b11 behave exactly like 2'b00.
- R10: The excursion count saturates at 15 and never wraps.
- R11: After reset the pin `irq_n` is high, nothing is pending and the count is zero.
- R12: The pin is active-low. It goes low in the same clock edge that samples the firing conversion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is valid |
| conv_value | input | 16 | Conversion result |
| lo_limit | input | 16 | Lower window limit |
| hi_limit | input | 16 | Upper window limit |
| persist_code | input | 4 | Persistence rule select |
| irq_mode | input | 2 | Interrupt mode (2'b01 armed, other codes off) |
| irq_clear | input | 1 | One-cycle pulse that drops a pending interrupt |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
Several rules are checked by assertions on every clock:
- code 0 always fires;
- an in-window result zeroes the count;
- a pending interrupt holds until cleared or disabled;
- a clear empties both the count and the pending flag;
- a disabled block keeps them empty;
- a saturated count stays at its maximum.

Some behaviour is only visible as whole sequences, and the bench scenarios show those:
- the exact conversion on which codes 2 to 15 fire;
- the inclusive treatment of results equal to a limit;
- a clear winning over a simultaneous strobe;
- the reserved mode codes behaving as off;
- the full fresh run needed after a re-arm.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'b00,
    IRQ_ARMED = 2'b01,
    IRQ_RSV2  = 2'b10,
    IRQ_RSV3  = 2'b11
  } irq_mode_e;

  // Only the armed code enables the interrupt; reserved codes act as off (R9)
  function automatic logic mode_armed(input logic [1:0] mode);
    return mode == IRQ_ARMED;
  endfunction

endpackage

// File: rtl/thr_window_cmp.sv
module thr_window_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              out_of_win
);

  // Strict comparisons: equality with a limit is inside the window (R1)
  function automatic logic outside(input logic [DATA_W-1:0] v,
                                   input logic [DATA_W-1:0] l,
                                   input logic [DATA_W-1:0] h);
    return (v < l) || (v > h);
  endfunction

  assign out_of_win = outside(value, lo, hi);

endmodule

// File: rtl/thr_persist_ctr.sv
module thr_persist_ctr #(
  parameter int unsigned PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              conv_done,
  input  logic              oor,
  input  logic [PERS_W-1:0] code,
  input  logic              clear,
  output logic              pending
);

  localparam int unsigned CNT_MAX = (1 << PERS_W) - 1;
  localparam logic [PERS_W-1:0] CNT_TOP = CNT_MAX[PERS_W-1:0];

  logic [PERS_W-1:0] cnt;
  logic [PERS_W-1:0] next_cnt;
  logic              fire;
  logic              take_evt;   // accepted conversion this cycle
  logic              flush_evt;  // count and pending forced empty

  function automatic logic [PERS_W-1:0] sat_inc(input logic [PERS_W-1:0] c);
    return (c == CNT_TOP) ? c : c + 1'b1;
  endfunction

  function automatic logic fire_rule(input logic [PERS_W-1:0] pcode,
                                     input logic              out,
                                     input logic [PERS_W-1:0] run);
    return (pcode == '0) || (out && (run >= pcode));
  endfunction

  assign take_evt  = enable && conv_done && !clear;
  assign flush_evt = !enable || clear;
  assign next_cnt  = oor ? sat_inc(cnt) : '0;
  assign fire      = fire_rule(code, oor, next_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (flush_evt) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (take_evt) begin
      cnt <= next_cnt;
      if (fire) pending <= 1'b1;
    end
  end

  a_r2_code0_fires: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt && (code == '0) |=> pending);

  a_r5_inwin_resets: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt && !oor |=> cnt == '0);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pending && enable && !clear |=> pending);

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending && (cnt == '0));

  a_r8_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pending && (cnt == '0));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt && oor && (cnt == CNT_TOP) |=> cnt == CNT_TOP);

  a_r4_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt && !pending && (code > 1) && (cnt < code - 1'b1) |=> !pending);

endmodule

// File: rtl/thr_irq_filter.sv
module thr_irq_filter
  import thr_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_value,
  input  logic [DATA_W-1:0] lo_limit,
  input  logic [DATA_W-1:0] hi_limit,
  input  logic [PERS_W-1:0] persist_code,
  input  logic [1:0]        irq_mode,
  input  logic              irq_clear,
  output logic              irq_n
);

  logic armed;
  logic out_of_win;
  logic pending;

  assign armed = mode_armed(irq_mode);

  thr_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value      (conv_value),
    .lo         (lo_limit),
    .hi         (hi_limit),
    .out_of_win (out_of_win)
  );

  thr_persist_ctr #(.PERS_W(PERS_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (armed),
    .conv_done (conv_done),
    .oor       (out_of_win),
    .code      (persist_code),
    .clear     (irq_clear),
    .pending   (pending)
  );

  // Pin is driven low only while armed and pending (R8, R12)
  assign irq_n = ~(pending & armed);

  a_r9_rsv_modes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mode[1] |-> irq_n);

  a_r12_fire_drives_pin: assert property (@(posedge clk) disable iff (!rst_n)
    armed && conv_done && !irq_clear && (persist_code == '0) && $stable(irq_mode)
      |=> (irq_n == 1'b0) || (irq_mode != IRQ_ARMED));

endmodule

// File: tb/thr_irq_filter_tb.sv
module thr_irq_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] conv_value = '0;
  logic [15:0] lo_limit = 16'd1000;
  logic [15:0] hi_limit = 16'd2000;
  logic [3:0]  persist_code = '0;
  logic [1:0]  irq_mode = 2'b01;
  logic        irq_clear = 1'b0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [15:0] IN_V  = 16'd1500;
  localparam logic [15:0] LOW_V = 16'd10;
  localparam logic [15:0] HI_V  = 16'd5000;

  always #10 clk = ~clk;

  thr_irq_filter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .conv_value   (conv_value),
    .lo_limit     (lo_limit),
    .hi_limit     (hi_limit),
    .persist_code (persist_code),
    .irq_mode     (irq_mode),
    .irq_clear    (irq_clear),
    .irq_n        (irq_n)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (irq_n !== exp) begin
      fails++;
      $display("FAIL %s: irq_n actual %b expected %b", req, irq_n, exp);
    end
  endtask

  // One strobe; result sampled at the following negedge
  task automatic conv(input logic [15:0] v, input logic clr = 1'b0);
    @(negedge clk);
    conv_value = v; conv_done = 1'b1; irq_clear = clr;
    @(negedge clk);
    conv_done = 1'b0; irq_clear = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset state", 1'b1);
  endtask

  task automatic t_bounds();
    persist_code = 4'd1;
    conv(16'd1000); check("R1 equal low limit inside", 1'b1);
    conv(16'd2000); check("R1 equal high limit inside", 1'b1);
    conv(16'd999);  check("R3/R12 one below low fires", 1'b0);
    do_clear();     check("R6 clear releases", 1'b1);
    conv(16'd2001); check("R3 one above high fires", 1'b0);
    do_clear();
  endtask

  task automatic t_code0();
    persist_code = 4'd0;
    conv(IN_V); check("R2 in-window fires with code 0", 1'b0);
    do_clear();
  endtask

  task automatic t_codeN();
    persist_code = 4'd4;
    for (int i = 0; i < 3; i++) conv(LOW_V);
    check("R4 no fire before 4th", 1'b1);
    conv(HI_V); check("R4 fires on 4th", 1'b0);
    do_clear();
  endtask

  task automatic t_contig();
    persist_code = 4'd3;
    conv(LOW_V); conv(LOW_V); conv(IN_V); conv(LOW_V); conv(LOW_V);
    check("R5 broken run does not fire", 1'b1);
    conv(LOW_V); check("R5 fires after fresh run of 3", 1'b0);
    do_clear();
  endtask

  task automatic t_sticky();
    persist_code = 4'd1;
    conv(LOW_V);
    conv(IN_V); conv(IN_V);
    check("R6 stays asserted through in-window results", 1'b0);
    do_clear(); check("R6 clear deasserts", 1'b1);
    persist_code = 4'd3;
    conv(LOW_V); conv(LOW_V);
    check("R6 count restarted after clear", 1'b1);
    conv(LOW_V); check("R6 fires on 3rd after clear", 1'b0);
    do_clear();
  endtask

  task automatic t_clear_wins();
    persist_code = 4'd2;
    conv(LOW_V);
    conv(LOW_V, 1'b1);
    check("R7 strobe with clear discarded", 1'b1);
    conv(LOW_V); check("R7 count restarted, one excursion", 1'b1);
    conv(LOW_V); check("R7 fires after two new", 1'b0);
    do_clear();
    persist_code = 4'd0;
    conv(IN_V, 1'b1); check("R7 code 0 strobe with clear discarded", 1'b1);
  endtask

  task automatic t_off();
    persist_code = 4'd1;
    irq_mode = 2'b00;
    conv(LOW_V); check("R8 disabled pin stays high", 1'b1);
    irq_mode = 2'b01;
    @(negedge clk); check("R8 no stale pending on re-arm", 1'b1);
    persist_code = 4'd2;
    conv(LOW_V);
    @(negedge clk); irq_mode = 2'b00;
    @(negedge clk); irq_mode = 2'b01;
    conv(LOW_V); check("R8 count zeroed while off", 1'b1);
    conv(LOW_V); check("R8 fires after fresh run", 1'b0);
    irq_mode = 2'b00; #1;
    check("R8 pin high at once when disabled", 1'b1);
    @(negedge clk); irq_mode = 2'b01;
    @(negedge clk); check("R8 pending dropped while off", 1'b1);
  endtask

  task automatic t_rsv();
    persist_code = 4'd0;
    irq_mode = 2'b10;
    conv(LOW_V); check("R9 mode 10 acts off", 1'b1);
    irq_mode = 2'b11;
    conv(LOW_V); check("R9 mode 11 acts off", 1'b1);
    irq_mode = 2'b01;
    @(negedge clk); check("R9 nothing pending after reserved modes", 1'b1);
  endtask

  task automatic t_sat();
    persist_code = 4'd15;
    for (int i = 0; i < 14; i++) conv(HI_V);
    check("R4 code 15 quiet after 14", 1'b1);
    conv(HI_V); check("R4 code 15 fires on 15th", 1'b0);
    for (int i = 0; i < 6; i++) conv(HI_V);
    check("R10 stays asserted past saturation", 1'b0);
    do_clear();
    for (int i = 0; i < 14; i++) conv(HI_V);
    check("R10 count restarted, no wrap carry", 1'b1);
    conv(HI_V); check("R10 fires again on 15th", 1'b0);
    do_clear();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bounds();
    t_code0();
    t_codeN();
    t_contig();
    t_sticky();
    t_clear_wins();
    t_off();
    t_rsv();
    t_sat();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule